// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block collects up to eight peripheral interrupt lines and presents them to a processor as a single interrupt request. Each input is edge-captured into a pending register. A per-input mask can hold a pending input back. A priority resolver picks the winning input and compares it against the inputs already being serviced, so that only a more urgent source can interrupt a handler that is running.

The processor answers `intr` with a one-cycle `inta` pulse. On the next cycle the block emits an 8-bit vector made of a programmable 5-bit base and the 3-bit winner index. At the same time the winner moves from pending to in-service. A small write port loads the mask and the control word, and it carries the end-of-service command. In fixed mode input 0 ranks highest. In rotating mode the input whose service has just ended drops to the bottom of the order.

The vector leaves as a valid-only stream: `vec_vld` is high for exactly one cycle, and the processor has no way to stall it. The block offers no back-pressure because the vector is only produced in reply to the processor's own `inta`.

Top module: `pic_core`

## Requirements
- R1: After reset, `intr` and `vec_vld` are low, and every input is masked (mask register all ones), so a request on any input leaves `intr` low.
- R2: A pending bit is set by a 0-to-1 transition of its input and stays set after the input falls. An input held high does not set it again once it has been serviced; only a new rising edge does.
- R3: Writing address 0 loads the mask, where bit i = 1 holds input i back. A masked pending input never raises `intr` and never wins. It stays pending and can win once it is unmasked.
- R4: One cycle after an accepted `inta`, `vec_vld` is high for one cycle. `vec[7:3]` holds the base and `vec[2:0]` holds the winner index. Writing address 1 sets the base from data bits [7:3] and the rotating mode from data bit 0.
- R5: An accepted `inta` clears the winner's pending bit and sets its in-service bit.
- R6: `intr` is high only when an unmasked pending input ranks strictly above every in-service input. A more urgent input may therefore preempt one in service, and a less urgent one waits.
- R7: Writing address 2 (data ignored) ends service of the highest-ranked in-service input. With nothing in service it has no effect.
- R8: In fixed mode input 0 ranks highest and input 7 lowest. In rotating mode, ending service of input k makes k the lowest rank and k+1 (mod 8) the highest. The order is unchanged when nothing was in service.
- R9: An `inta` while `intr` is low is ignored: `vec_vld` stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Peripheral request lines |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | 0 mask, 1 control, 2 end-of-service |
| cfg_wdata | input | 8 | Write data |
| inta | input | 1 | Processor acknowledge pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_vld | output | 1 | Vector valid, one cycle |
| vec | output | 8 | Base and winner index |

## Verification
On every cycle, the assertions check four things: that `intr` always has an unmasked pending source behind it; that a vector appears only after an accepted acknowledge; that a stray acknowledge produces no vector; and that the in-service set grows by one on a grant and shrinks by one on an end-of-service command. The bench scenarios cover what needs an order of events. These are the winner of every pair of inputs, preemption and blocking between nested sources, and edge-versus-level capture. They also cover the full rotating sequence after service ends on a chosen input, and vector contents under a non-zero base.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned CFG_ADDR_W = 2;
  typedef enum logic [CFG_ADDR_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_EOI  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/pic_rank_pick.sv
module pic_rank_pick #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned N = 1 << IDX_W
) (
  input  logic [N-1:0]     bits,
  input  logic [IDX_W-1:0] top,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W:0]   rank
);
  logic [N-1:0] rot;

  // rot[j] is the input sitting j places below the current top rank
  for (genvar j = 0; j < N; j++) begin : g_rot
    assign rot[j] = bits[top + IDX_W'(j)];
  end

  always_comb begin
    rank = (IDX_W+1)'(N);
    for (int j = N-1; j >= 0; j--) begin
      if (rot[j]) rank = (IDX_W+1)'(j);
    end
    any = ~rank[IDX_W];
    idx = top + rank[IDX_W-1:0];
  end
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] take,
  output logic [N-1:0] pend
);
  logic [N-1:0] last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= '0;
      pend <= '0;
    end else begin
      last <= lines;
      pend <= (pend & ~take) | (lines & ~last);
    end
  end
endmodule

// File: rtl/pic_svc_reg.sv
module pic_svc_reg #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned N = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_oh,
  input  logic [N-1:0]     clr_oh,
  input  logic             top_ld,
  input  logic [IDX_W-1:0] top_nxt,
  output logic [N-1:0]     busy,
  output logic [IDX_W-1:0] top_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= '0;
      top_q <= '0;
    end else begin
      busy <= (busy & ~clr_oh) | set_oh;
      if (top_ld) top_q <= top_nxt;
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned N = 1 << IDX_W,
  localparam int unsigned BASE_W = VEC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [N-1:0]     cfg_wdata,
  input  logic             inta,
  output logic             intr,
  output logic             vec_vld,
  output logic [VEC_W-1:0] vec
);
  import pic_pkg::*;

  logic [N-1:0]      mask_q;
  logic [BASE_W-1:0] base_q;
  logic              rot_q;
  logic [N-1:0]      irr_q;
  logic [N-1:0]      isr_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [IDX_W-1:0]  hi;
  logic              req_any, isr_any;
  logic [IDX_W-1:0]  req_idx, isr_idx;
  logic [IDX_W:0]    req_rank, isr_rank;
  logic              grant, eoi;
  logic [N-1:0]      grant_oh, eoi_oh;

  assign hi = rot_q ? ptr_q : '0;

  pic_req_reg #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .take(grant_oh), .pend(irr_q)
  );

  pic_rank_pick #(.IDX_W(IDX_W)) u_pick_req (
    .bits(irr_q & ~mask_q), .top(hi), .any(req_any), .idx(req_idx), .rank(req_rank)
  );

  pic_rank_pick #(.IDX_W(IDX_W)) u_pick_isr (
    .bits(isr_q), .top(hi), .any(isr_any), .idx(isr_idx), .rank(isr_rank)
  );

  assign intr     = req_any && (req_rank < isr_rank);
  assign grant    = inta && intr;
  assign grant_oh = grant ? (N'(1) << req_idx) : '0;
  assign eoi      = cfg_wr && (cfg_addr == SEL_EOI);
  assign eoi_oh   = (eoi && isr_any) ? (N'(1) << isr_idx) : '0;

  pic_svc_reg #(.IDX_W(IDX_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .set_oh(grant_oh), .clr_oh(eoi_oh),
    .top_ld(eoi && isr_any && rot_q), .top_nxt(isr_idx + 1'b1),
    .busy(isr_q), .top_q(ptr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= '0;
      rot_q  <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_addr == SEL_MASK) mask_q <= cfg_wdata;
      if (cfg_addr == SEL_CTRL) begin
        base_q <= cfg_wdata[N-1 -: BASE_W];
        rot_q  <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_vld <= 1'b0;
      vec     <= '0;
    end else begin
      vec_vld <= grant;
      if (grant) vec <= {base_q, req_idx};
    end
  end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         inta,
  input logic         cfg_wr,
  input logic [1:0]   cfg_addr,
  input logic         intr,
  input logic         vec_vld,
  input logic [N-1:0] irr,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask
);
  // R9
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !intr) |=> !vec_vld);

  // R4
  vec_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(inta && intr));

  // R3
  intr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr |-> ((irr & ~mask) != '0));

  // R5
  grant_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && intr && !(cfg_wr && cfg_addr == 2'd2))
      |=> ($countones(isr) == $past($countones(isr)) + 1));

  // R7
  eoi_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd2 && isr != '0 && !inta)
      |=> ($countones(isr) == $past($countones(isr)) - 1));
endmodule

bind pic_core pic_core_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .intr(intr), .vec_vld(vec_vld), .irr(irr_q), .isr(isr_q), .mask(mask_q)
);

// File: tb/sim_pic_core.sv
module sim_pic_core;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 21;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       inta = 1'b0;
  logic       intr, vec_vld;
  logic [7:0] vec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  pic_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .inta(inta), .intr(intr), .vec_vld(vec_vld), .vec(vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic eoi();
    cfg(2'd2, 8'h00);
  endtask

  task automatic raise(input int i);
    @(negedge clk); irq[i] = 1'b1;
    @(negedge clk);
  endtask

  task automatic drop_all();
    @(negedge clk); irq = '0;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v, output logic vl);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    v = vec; vl = vec_vld;
  endtask

  task automatic ack_expect(input int idx, input string tag);
    logic [7:0] v; logic vl;
    ack(v, vl);
    chk(vl === 1'b1, tag, int'(vl), 1);
    chk(v === 8'(BASE*8 + idx), tag, int'(v), BASE*8 + idx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; logic vl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(intr === 1'b0, "R1 intr after reset", int'(intr), 0);
    chk(vec_vld === 1'b0, "R1 vec_vld after reset", int'(vec_vld), 0);
    raise(0);
    chk(intr === 1'b0, "R1 all masked at reset", int'(intr), 0);
    cfg(2'd0, 8'h00);
    chk(intr === 1'b1, "R3 unmask releases pending", int'(intr), 1);
    ack(v, vl);
    chk(v === 8'd0 && vl === 1'b1, "R4 vector with base 0", int'(v), 0);
    @(negedge clk);
    chk(vec_vld === 1'b0, "R4 vec_vld one cycle", int'(vec_vld), 0);
    eoi(); drop_all();

    cfg(2'd1, 8'(BASE << 3));
    // single sources, level held high across service
    for (int i = 0; i < 8; i++) begin
      raise(i);
      chk(intr === 1'b1, "R2 edge sets pending", int'(intr), 1);
      ack_expect(i, "R4 single source vector");
      chk(intr === 1'b0, "R5 grant clears pending", int'(intr), 0);
      eoi();
      chk(intr === 1'b0, "R2 held level no retrigger", int'(intr), 0);
      drop_all();
    end

    // every pair in fixed order
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        raise(j); raise(i);
        ack_expect(i, "R8 fixed pair winner");
        chk(intr === 1'b0, "R6 lower waits behind in-service", int'(intr), 0);
        eoi();
        chk(intr === 1'b1, "R7 eoi lets lower through", int'(intr), 1);
        ack_expect(j, "R8 fixed pair second");
        eoi(); drop_all();
      end
    end

    // nesting
    raise(5); ack_expect(5, "R6 nest outer");
    raise(2);
    chk(intr === 1'b1, "R6 higher preempts", int'(intr), 1);
    ack_expect(2, "R6 nest inner");
    raise(7);
    chk(intr === 1'b0, "R6 lower blocked", int'(intr), 0);
    eoi();
    chk(intr === 1'b0, "R7 eoi clears highest (2 not 5)", int'(intr), 0);
    eoi();
    chk(intr === 1'b1, "R7 second eoi clears 5", int'(intr), 1);
    ack_expect(7, "R6 nest late");
    eoi(); drop_all();

    // pulse shorter than service: pending kept after input falls
    raise(4); drop_all();
    chk(intr === 1'b1, "R2 pending kept after fall", int'(intr), 1);
    ack_expect(4, "R2 pulse served");
    eoi();
    raise(4);
    chk(intr === 1'b1, "R2 new edge sets again", int'(intr), 1);
    ack_expect(4, "R2 second edge served");
    eoi(); drop_all();

    // mask blocks a higher source
    cfg(2'd0, 8'h02);
    raise(1); raise(6);
    ack_expect(6, "R3 masked input skipped");
    eoi();
    chk(intr === 1'b0, "R3 masked stays silent", int'(intr), 0);
    cfg(2'd0, 8'h00);
    chk(intr === 1'b1, "R3 unmask later", int'(intr), 1);
    ack_expect(1, "R3 unmasked served");
    eoi(); drop_all();

    // stray acknowledge
    ack(v, vl);
    chk(vl === 1'b0, "R9 stray inta no vector", int'(vl), 0);
    raise(3);
    ack_expect(3, "R9 state untouched");
    eoi(); drop_all();

    // rotating mode
    cfg(2'd1, 8'((BASE << 3) | 1));
    eoi();
    raise(7); raise(0);
    ack_expect(0, "R8 empty eoi keeps order");
    eoi(); drop_all();
    raise(5); ack_expect(5, "R8 set rotation point"); eoi(); drop_all();
    for (int i = 0; i < 8; i++) raise(i);
    for (int n = 0; n < 8; n++) begin
      ack_expect((6 + n) % 8, "R8 rotated sequence");
      eoi();
    end
    chk(intr === 1'b0, "R8 all served", int'(intr), 0);
    drop_all();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule